// File: doc/BRIEF.md
# Descriptor Completion Notification Controller

This block sits at the tail of a crypto channel's descriptor pipeline and decides how each finished descriptor is reported to the host. When a descriptor completes, it looks at five configuration bits, the descriptor's per-header notify flag, whether integrity checking was in use, and whether an execution unit flagged an error. From these it decides three things: whether to set a sticky done interrupt, whether to set a sticky error interrupt, and which header fields the memory side must write back.

The host reaches the block through a small register port with two registers. The control register (address 0) holds the configuration bits and a self-clearing channel reset bit. The status register (address 1) holds the two sticky interrupt bits, and each is cleared by writing 1 to it. While the channel reset runs, the block ignores completions. Software starts the reset and then polls the control register until the reset bit reads 0 again.

Top module: `cdn_ctrl`

## Requirements
- R1: The done status bit (status bit 0, also `done_irq_o`) is set by an error-free completion when the done interrupt enable (control bit 0) is 1 and the descriptor needs notifying. A descriptor needs notifying when selective mode (control bit 1) is 0, or when `cmpl_dn_i` is 1.
- R2: When always-writeback (control bit 4) is 1, an error-free completion writes back all three fields (`wb_fields_o` = 3'b111).
- R3: When integrity writeback (control bit 3) is 1 and `icv_used_i` is 1, an error-free completion writes back all three fields.
- R4: If neither R2 nor R3 applies, a done writeback (`wb_fields_o` = 3'b001) is issued only when done writeback (control bit 2) is 1 and the descriptor needs notifying. Otherwise no writeback is issued.
- R5: A completion with `eu_err_i` = 1 sets the error status bit (status bit 1, also `err_irq_o`). It issues no writeback and does not set the done bit.
- R6: `wb_valid_o` is high for exactly the one cycle after an accepted completion strobe. It is high only when at least one field is enabled. The `wb_fields_o` bits are ordered {ICCR1, ICCR0, DONE}, from bit 2 down to bit 0.
- R7: Writing 1 to a status bit clears it. If a clear write and a new setting event fall in the same cycle, the bit stays set.
- R8: Writing 1 to control bit 5 starts a channel reset. Control bit 5 and `chan_rst_o` then read 1 for RST_CYCLES cycles (16 by default) and clear by themselves. A start write made while the reset is running does not restart it.
- R9: A completion strobe that arrives while the channel reset is running produces no writeback and no status change.
- R10: After `rst_ni`, all configuration and status bits are 0, and no writeback or channel reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 is control, 1 is status |
| reg_wdata_i | input | 6 | Register write data |
| reg_rdata_o | output | 6 | Read data for the selected register |
| cmpl_i | input | 1 | Descriptor complete strobe |
| cmpl_dn_i | input | 1 | Per-descriptor notify flag from the header |
| icv_used_i | input | 1 | Descriptor used integrity checking |
| eu_err_i | input | 1 | Execution unit reported an error |
| wb_valid_o | output | 1 | One-cycle writeback command |
| wb_fields_o | output | 3 | Writeback field enables {ICCR1, ICCR0, DONE} |
| done_irq_o | output | 1 | Sticky done interrupt |
| err_irq_o | output | 1 | Sticky error interrupt |
| chan_rst_o | output | 1 | Channel reset in progress |

## Verification
Two functions can fall in the same cycle: software clearing a sticky status bit, and a completion strobe setting that same bit. The bench provokes this by driving a write-1-to-clear to the status register on the same edge as an error-free, notifying completion. It judges the result by reading back that the done bit stayed set, and then that a plain clear write on its own does clear it. A second overlap is tested by pulsing a completion strobe and a repeated reset-start write while the channel reset is running. Both must leave the writeback output and the status register unchanged, and the reset length must stay unchanged.

// File: rtl/cdn_pkg.sv
package cdn_pkg;
  localparam int REG_W = 6;
  localparam int FLD_W = 3;

  localparam int CB_IRQ_EN  = 0;
  localparam int CB_SEL     = 1;
  localparam int CB_DONE_WB = 2;
  localparam int CB_ICV_WB  = 3;
  localparam int CB_ALW_WB  = 4;
  localparam int CB_RST     = 5;

  localparam int SB_DONE = 0;
  localparam int SB_ERR  = 1;

  localparam logic [FLD_W-1:0] FLD_NONE = 3'b000;
  localparam logic [FLD_W-1:0] FLD_DONE = 3'b001;
  localparam logic [FLD_W-1:0] FLD_ALL  = 3'b111;

  typedef struct packed {
    logic always_wb;
    logic icv_wb;
    logic done_wb;
    logic sel_notify;
    logic done_irq_en;
  } cdn_cfg_t;
endpackage

// File: rtl/cdn_decide.sv
module cdn_decide
  import cdn_pkg::*;
(
  input  cdn_cfg_t         cfg_i,
  input  logic             dn_i,
  input  logic             icv_i,
  input  logic             err_i,
  output logic [FLD_W-1:0] fields_o,
  output logic             done_set_o,
  output logic             err_set_o
);
  logic notify;

  always_comb begin
    notify = !cfg_i.sel_notify || dn_i;
    if (cfg_i.always_wb || (cfg_i.icv_wb && icv_i)) fields_o = FLD_ALL;
    else if (cfg_i.done_wb && notify)              fields_o = FLD_DONE;
    else                                           fields_o = FLD_NONE;
    // any unit error suppresses every completion report
    if (err_i) fields_o = FLD_NONE;
    done_set_o = !err_i && cfg_i.done_irq_en && notify;
    err_set_o  = err_i;
  end
endmodule

// File: rtl/cdn_rst_seq.sv
module cdn_rst_seq #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (start_i && cnt_q == '0)   cnt_q <= CNT_W'(RST_CYCLES);
    else if (cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/cdn_regs.sv
module cdn_regs
  import cdn_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             busy_i,
  input  logic             done_set_i,
  input  logic             err_set_i,
  output cdn_cfg_t         cfg_o,
  output logic             rst_go_o,
  output logic             done_o,
  output logic             err_o,
  output logic [REG_W-1:0] rdata_o
);
  logic ctrl_we, stat_we;
  cdn_cfg_t cfg_q;
  logic done_q, err_q;

  assign ctrl_we  = we_i && !addr_i;
  assign stat_we  = we_i && addr_i;
  assign rst_go_o = ctrl_we && wdata_i[CB_RST] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (ctrl_we) begin
      cfg_q.done_irq_en <= wdata_i[CB_IRQ_EN];
      cfg_q.sel_notify  <= wdata_i[CB_SEL];
      cfg_q.done_wb     <= wdata_i[CB_DONE_WB];
      cfg_q.icv_wb      <= wdata_i[CB_ICV_WB];
      cfg_q.always_wb   <= wdata_i[CB_ALW_WB];
    end
  end

  // set wins over a simultaneous write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_set_i || (done_q && !(stat_we && wdata_i[SB_DONE]));
      err_q  <= err_set_i  || (err_q  && !(stat_we && wdata_i[SB_ERR]));
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!addr_i) begin
      rdata_o[CB_IRQ_EN]  = cfg_q.done_irq_en;
      rdata_o[CB_SEL]     = cfg_q.sel_notify;
      rdata_o[CB_DONE_WB] = cfg_q.done_wb;
      rdata_o[CB_ICV_WB]  = cfg_q.icv_wb;
      rdata_o[CB_ALW_WB]  = cfg_q.always_wb;
      rdata_o[CB_RST]     = busy_i;
    end else begin
      rdata_o[SB_DONE] = done_q;
      rdata_o[SB_ERR]  = err_q;
    end
  end

  assign cfg_o  = cfg_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/cdn_ctrl.sv
module cdn_ctrl
  import cdn_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             cmpl_i,
  input  logic             cmpl_dn_i,
  input  logic             icv_used_i,
  input  logic             eu_err_i,
  output logic             wb_valid_o,
  output logic [FLD_W-1:0] wb_fields_o,
  output logic             done_irq_o,
  output logic             err_irq_o,
  output logic             chan_rst_o
);
  cdn_cfg_t         cfg;
  logic             busy, rst_go, accept;
  logic [FLD_W-1:0] fields;
  logic             done_hit, err_hit;
  logic             wb_valid_q;
  logic [FLD_W-1:0] wb_fields_q;

  assign accept = cmpl_i && !busy;

  cdn_decide u_decide (
    .cfg_i      (cfg),
    .dn_i       (cmpl_dn_i),
    .icv_i      (icv_used_i),
    .err_i      (eu_err_i),
    .fields_o   (fields),
    .done_set_o (done_hit),
    .err_set_o  (err_hit)
  );

  cdn_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rst_go),
    .busy_o  (busy)
  );

  cdn_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .busy_i     (busy),
    .done_set_i (accept && done_hit),
    .err_set_i  (accept && err_hit),
    .cfg_o      (cfg),
    .rst_go_o   (rst_go),
    .done_o     (done_irq_o),
    .err_o      (err_irq_o),
    .rdata_o    (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_q  <= 1'b0;
      wb_fields_q <= FLD_NONE;
    end else begin
      wb_valid_q  <= accept && (fields != FLD_NONE);
      wb_fields_q <= accept ? fields : FLD_NONE;
    end
  end

  assign wb_valid_o  = wb_valid_q;
  assign wb_fields_o = wb_fields_q;
  assign chan_rst_o  = busy;
endmodule

// File: rtl/cdn_ctrl_chk.sv
module cdn_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic       reg_addr_i,
  input logic [5:0] reg_wdata_i,
  input logic       cmpl_i,
  input logic       eu_err_i,
  input logic       wb_valid_o,
  input logic [2:0] wb_fields_o,
  input logic       done_irq_o,
  input logic       err_irq_o,
  input logic       chan_rst_o
);
  p_err_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && eu_err_i && !chan_rst_o) |=> (err_irq_o && !wb_valid_o));

  p_err_no_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && eu_err_i && !chan_rst_o && !done_irq_o) |=> !done_irq_o);

  p_wb_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wb_valid_o) |-> $past(cmpl_i));

  p_wb_fields_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (wb_fields_o != 3'b000));

  p_rst_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && chan_rst_o) |=> !wb_valid_o);

  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_irq_o && !(reg_we_i && reg_addr_i && reg_wdata_i[0])) |=> done_irq_o);

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_irq_o && !(reg_we_i && reg_addr_i && reg_wdata_i[1])) |=> err_irq_o);
endmodule

bind cdn_ctrl cdn_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .cmpl_i      (cmpl_i),
  .eu_err_i    (eu_err_i),
  .wb_valid_o  (wb_valid_o),
  .wb_fields_o (wb_fields_o),
  .done_irq_o  (done_irq_o),
  .err_irq_o   (err_irq_o),
  .chan_rst_o  (chan_rst_o)
);

// File: tb/cdn_ctrl_tb.sv
module cdn_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 16;
  localparam int NVEC       = 13;
  // {alw, icv_en, done_wb, sel, irq_en, dn, icv_used, err} | wbv | fields[2:0] | done | err
  localparam logic [13:0] VEC [NVEC] = '{
    {8'b0000_1000, 1'b0, 3'b000, 1'b1, 1'b0},
    {8'b0001_1000, 1'b0, 3'b000, 1'b0, 1'b0},
    {8'b0001_1100, 1'b0, 3'b000, 1'b1, 1'b0},
    {8'b1001_0000, 1'b1, 3'b111, 1'b0, 1'b0},
    {8'b0010_0000, 1'b1, 3'b001, 1'b0, 1'b0},
    {8'b0011_0000, 1'b0, 3'b000, 1'b0, 1'b0},
    {8'b0011_0100, 1'b1, 3'b001, 1'b0, 1'b0},
    {8'b0100_0010, 1'b1, 3'b111, 1'b0, 1'b0},
    {8'b0111_0000, 1'b0, 3'b000, 1'b0, 1'b0},
    {8'b0100_0000, 1'b0, 3'b000, 1'b0, 1'b0},
    {8'b1110_1111, 1'b0, 3'b000, 1'b0, 1'b1},
    {8'b0010_1011, 1'b0, 3'b000, 1'b0, 1'b1},
    {8'b0000_0000, 1'b0, 3'b000, 1'b0, 1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we_i = 1'b0, reg_addr_i = 1'b0;
  logic [5:0] reg_wdata_i = '0;
  logic [5:0] reg_rdata_o;
  logic cmpl_i = 1'b0, cmpl_dn_i = 1'b0, icv_used_i = 1'b0, eu_err_i = 1'b0;
  logic wb_valid_o, done_irq_o, err_irq_o, chan_rst_o;
  logic [2:0] wb_fields_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  cdn_ctrl #(.RST_CYCLES(RST_CYC)) u_dut (.*);

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic a, input logic [5:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic a, output logic [5:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic strobe(input logic dn, input logic icv, input logic err);
    cmpl_i = 1'b1; cmpl_dn_i = dn; icv_used_i = icv; eu_err_i = err;
    @(posedge clk_i); @(negedge clk_i);
    cmpl_i = 1'b0; cmpl_dn_i = 1'b0; icv_used_i = 1'b0; eu_err_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [5:0] r;
    int c0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    rd(1'b0, r); chk(r, 0, "R10 ctrl after reset");
    rd(1'b1, r); chk(r, 0, "R10 status after reset");
    chk(wb_valid_o, 0, "R10 wb_valid after reset");
    chk(chan_rst_o, 0, "R10 chan_rst after reset");

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      logic [13:0] v;
      v = VEC[i];
      reg_wr(1'b0, {1'b0, v[13], v[12], v[11], v[10], v[9]});
      reg_wr(1'b1, 6'b000011);
      strobe(v[8], v[7], v[6]);
      chk(wb_valid_o, v[5], $sformatf("R6 wb_valid vec%0d", i));
      chk(wb_fields_o, v[4:2], $sformatf("R2/R3/R4 fields vec%0d", i));
      chk(done_irq_o, v[1], $sformatf("R1 done vec%0d", i));
      chk(err_irq_o, v[0], $sformatf("R5 err vec%0d", i));
      @(negedge clk_i);
      chk(wb_valid_o, 0, $sformatf("R6 single pulse vec%0d", i));
    end

    // R7 set and clear in same cycle: set wins
    reg_wr(1'b0, 6'b000001);
    reg_wr(1'b1, 6'b000011);
    strobe(1'b0, 1'b0, 1'b0);
    chk(done_irq_o, 1, "R7 done set");
    reg_we_i = 1'b1; reg_addr_i = 1'b1; reg_wdata_i = 6'b000001;
    strobe(1'b0, 1'b0, 1'b0);
    reg_we_i = 1'b0; reg_wdata_i = '0;
    chk(done_irq_o, 1, "R7 set wins over clear");
    reg_wr(1'b1, 6'b000001);
    chk(done_irq_o, 0, "R7 clear alone");
    strobe(1'b0, 1'b0, 1'b1);
    reg_wr(1'b1, 6'b000001);
    chk(err_irq_o, 1, "R7 err kept when only bit0 cleared");
    reg_wr(1'b1, 6'b000010);
    chk(err_irq_o, 0, "R7 err cleared");

    // R8 R9 channel reset
    reg_wr(1'b0, 6'b110001);
    c0 = cyc;
    rd(1'b0, r);
    chk(r[5], 1, "R8 reset bit reads 1");
    chk(r[4:0], 5'b10001, "R8 config kept");
    chk(chan_rst_o, 1, "R8 chan_rst active");
    reg_wr(1'b0, 6'b110001);
    strobe(1'b1, 1'b1, 1'b0);
    chk(wb_valid_o, 0, "R9 no writeback during reset");
    rd(1'b1, r);
    chk(r, 0, "R9 no status during reset");
    strobe(1'b0, 1'b0, 1'b1);
    chk(err_irq_o, 0, "R9 error ignored during reset");
    do begin
      @(negedge clk_i);
      rd(1'b0, r);
    end while (r[5] && (cyc - c0) < 100);
    chk(cyc - c0, RST_CYC, "R8 reset length and no restart");
    chk(chan_rst_o, 0, "R8 chan_rst released");
    strobe(1'b1, 1'b0, 1'b0);
    chk(wb_valid_o, 1, "R9 completions accepted after reset");
    chk(wb_fields_o, 3'b111, "R2 fields after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule